// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the load/store stage of a processor and a data memory organised as 32-bit words with per-byte write enables. Each request carries a byte address, an access size, a read/write flag, a signedness flag for loads and the store data. In the same cycle, the block turns the request into a word address, a set of byte-lane enables and store data placed on those lanes. Memory read data returns combinationally in that cycle. The block then registers the loaded value after it has picked the lanes, rotated or extended the data.

Two runtime controls shape the mapping. `bigEndian` decides which lane holds the lowest byte address. `checkAlign` selects between two policies for misaligned accesses. With checking on, a misaligned request is refused and raises a one-cycle `abort`. With checking off, the access is truncated to its natural boundary. In that case a word load returns the aligned word rotated right by the byte offset.

Top module: `ls_align_unit`

## Requirements
- R1: `memAddr` always equals `reqAddr[ADDR_W-1:2]`, for every size and offset.
- R2: A byte store enables exactly one lane and repeats the low byte of `reqWdata` on all four lanes. The lane is offset (`reqAddr[1:0]`) in little-endian mode and 3 minus offset in big-endian mode.
- R3: A halfword store enables two lanes and repeats `reqWdata[15:0]` on both halves. With checking off, address bit 0 is ignored. Lanes {1,0} hold offset 0 in little-endian mode and offset 2 in big-endian mode; lanes {3,2} hold the other halfword. The higher lane carries the more significant byte.
- R4: A word store (`reqSize` 2 or 3) enables all four lanes with `reqWdata` unchanged. With checking off, address bits [1:0] are ignored.
- R5: A byte or halfword load returns the addressed data, sign-extended when `reqSigned` is 1 and zero-extended when it is 0. Big-endian mode places the byte at the lower address in the upper half of the halfword; little-endian mode places it in the lower half.
- R6: With checking off, a word load returns the word at the truncated address rotated right by 8 × `reqAddr[1:0]` bits. The word value reads the byte at the lowest address as its most significant byte in big-endian mode and as its least significant byte in little-endian mode.
- R7: With checking on, a halfword with address bit 0 set, or a word with nonzero bits [1:0], is a fault. A fault drives `memWe` low, pulses `abort` in the next cycle without `rspValid`, and leaves `rspData` and memory unchanged.
- R8: After reset, `rspValid`, `abort` and `rspData` are 0. Every non-faulting request gives exactly one `rspValid` pulse in the next cycle. An idle cycle gives neither `rspValid` nor `abort`.
- R9: After storing the word 0x12345678 at a word address A, a byte load at A returns 0x12 in big-endian mode and 0x78 in little-endian mode. A byte load at A+3 returns 0x78 in big-endian mode and 0x12 in little-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSigned | input | 1 | Sign-extend loaded byte or halfword |
| reqWdata | input | 32 | Store data, right-justified |
| bigEndian | input | 1 | Byte-order select |
| checkAlign | input | 1 | Fault misaligned accesses |
| memRdata | input | 32 | Word read from memory at memAddr |
| memAddr | output | ADDR_W-2 | Word address |
| memWe | output | 1 | Memory write strobe |
| memBe | output | 4 | Byte-lane write enables |
| memWdata | output | 32 | Lane-placed store data |
| rspValid | output | 1 | Non-faulting request completed |
| rspData | output | 32 | Last loaded value |
| abort | output | 1 | Alignment fault pulse |

## Verification
The memory-side outputs `memAddr`, `memWe`, `memBe` and `memWdata` are combinational in the request cycle. The bench samples them one nanosecond after driving the request at the falling edge, before the next rising edge. `rspValid`, `abort` and `rspData` are registered, so they are due one clock later. The bench samples them one nanosecond after that rising edge. A byte-addressed model in the bench predicts every load. After each faulting store, the following loads show whether memory was left untouched.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  localparam int DATA_W     = 32;
  localparam int LANE_COUNT = DATA_W / 8;
  localparam int LANE_IDX_W = $clog2(LANE_COUNT);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSizeE;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic                  wrEn;
    logic                  ldCapture;
    accSizeE               size;
    logic                  sext;
    logic                  bigEnd;
    logic [LANE_IDX_W-1:0] offs;
  } lsStrobeT;
endpackage

// File: rtl/ls_align_ctrl.sv
module ls_align_ctrl
  import ls_align_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqSize,
  input  logic                  reqWrite,
  input  logic                  reqSigned,
  input  logic [LANE_IDX_W-1:0] addrLow,
  input  logic                  bigEndian,
  input  logic                  checkAlign,
  output lsStrobeT              strb,
  output logic                  rspValid,
  output logic                  abort
);
  accSizeE size;
  logic    misaligned;
  logic    fault;

  always_comb begin
    case (reqSize)
      2'd0:    size = SZ_BYTE;
      2'd1:    size = SZ_HALF;
      default: size = SZ_WORD;
    endcase
    misaligned = ((size == SZ_HALF) && addrLow[0]) ||
                 ((size == SZ_WORD) && (addrLow != '0));
    fault = reqValid && checkAlign && misaligned;

    strb.wrEn      = reqValid && reqWrite && !fault;
    strb.ldCapture = reqValid && !reqWrite && !fault;
    strb.size      = size;
    strb.sext      = reqSigned;
    strb.bigEnd    = bigEndian;
    // Truncate to the natural boundary; a word keeps its offset for rotation
    strb.offs      = (size == SZ_HALF) ? {addrLow[LANE_IDX_W-1:1], 1'b0} : addrLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      abort    <= 1'b0;
    end else begin
      rspValid <= reqValid && !fault;
      abort    <= fault;
    end
  end
endmodule

// File: rtl/ls_align_dp.sv
module ls_align_dp
  import ls_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lsStrobeT              strb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [ADDR_W-3:0]     memAddr,
  output logic                  memWe,
  output logic [LANE_COUNT-1:0] memBe,
  output logic [DATA_W-1:0]     memWdata,
  output logic [DATA_W-1:0]     rspData
);
  logic [LANE_IDX_W-1:0] byteLane;
  logic [LANE_IDX_W-1:0] halfBase;
  logic [LANE_COUNT-1:0] laneSel;
  logic [7:0]            ldByte;
  logic [15:0]           ldHalf;
  logic [2*DATA_W-1:0]   dblWord;
  logic [DATA_W-1:0]     ldValue;

  assign memAddr = reqAddr[ADDR_W-1:2];
  assign memWe   = strb.wrEn;
  assign memBe   = strb.wrEn ? laneSel : '0;

  always_comb begin
    // In big-endian mode the lowest address sits in the highest lane
    byteLane = strb.offs ^ {LANE_IDX_W{strb.bigEnd}};
    halfBase = {strb.offs[LANE_IDX_W-1] ^ strb.bigEnd, 1'b0};
    ldByte   = memRdata[{byteLane, 3'b000} +: 8];
    ldHalf   = memRdata[{halfBase, 3'b000} +: 16];
    dblWord  = {memRdata, memRdata} >> {strb.offs, 3'b000};

    case (strb.size)
      SZ_BYTE: begin
        laneSel  = LANE_COUNT'(1) << byteLane;
        memWdata = {LANE_COUNT{reqWdata[7:0]}};
        ldValue  = {{(DATA_W-8){strb.sext & ldByte[7]}}, ldByte};
      end
      SZ_HALF: begin
        laneSel  = LANE_COUNT'(3) << halfBase;
        memWdata = {(LANE_COUNT/2){reqWdata[15:0]}};
        ldValue  = {{(DATA_W-16){strb.sext & ldHalf[15]}}, ldHalf};
      end
      default: begin
        laneSel  = '1;
        memWdata = reqWdata;
        ldValue  = dblWord[DATA_W-1:0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rspData <= '0;
    else if (strb.ldCapture) rspData <= ldValue;
  end
endmodule

// File: rtl/ls_align_unit.sv
module ls_align_unit
  import ls_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqSigned,
  input  logic [31:0]       reqWdata,
  input  logic              bigEndian,
  input  logic              checkAlign,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-3:0] memAddr,
  output logic              memWe,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              abort
);
  lsStrobeT strb;

  ls_align_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqSigned  (reqSigned),
    .addrLow    (reqAddr[1:0]),
    .bigEndian  (bigEndian),
    .checkAlign (checkAlign),
    .strb       (strb),
    .rspValid   (rspValid),
    .abort      (abort)
  );

  ls_align_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memBe    (memBe),
    .memWdata (memWdata),
    .rspData  (rspData)
  );
endmodule

// File: rtl/ls_align_chk.sv
module ls_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              checkAlign,
  input logic              memWe,
  input logic [3:0]        memBe,
  input logic              rspValid,
  input logic [31:0]       rspData,
  input logic              abort
);
  logic badReq;
  assign badReq = reqValid && checkAlign &&
                  (((reqSize == 2'd1) && reqAddr[0]) ||
                   ((reqSize[1]) && (reqAddr[1:0] != 2'd0)));

  a_r7_no_write_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    badReq |-> !memWe);
  a_r7_abort_next: assert property (@(posedge clk) disable iff (!rstN)
    badReq |=> (abort && !rspValid));
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> $stable(rspData));
  a_r8_rsp_next: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !badReq) |=> (rspValid && !abort));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !abort));
  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize == 2'd0) |-> ($countones(memBe) == 1));
  a_r3_half_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize == 2'd1) |-> (memBe == 4'b0011 || memBe == 4'b1100));
  a_r4_word_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize[1]) |-> (memBe == 4'b1111));
endmodule

bind ls_align_unit ls_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqSize    (reqSize),
  .checkAlign (checkAlign),
  .memWe      (memWe),
  .memBe      (memBe),
  .rspValid   (rspValid),
  .rspData    (rspData),
  .abort      (abort)
);

// File: tb/ls_align_unit_bench.sv
`timescale 1ns/1ps
module ls_align_unit_bench;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic              reqWrite = 1'b0;
  logic              reqSigned = 1'b0;
  logic [31:0]       reqWdata = '0;
  logic              bigEndian = 1'b0;
  logic              checkAlign = 1'b0;
  logic [31:0]       memRdata;
  logic [ADDR_W-3:0] memAddr;
  logic              memWe;
  logic [3:0]        memBe;
  logic [31:0]       memWdata;
  logic              rspValid;
  logic [31:0]       rspData;
  logic              abort;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  ls_align_unit #(.ADDR_W(ADDR_W)) u_ls_align_unit (.*);

  // Word memory with lane enables, plus a bench preload path
  logic [31:0] wordMem [4];
  logic        preload = 1'b0;
  logic [1:0]  preIdx = '0;
  logic [31:0] preWord = '0;
  assign memRdata = wordMem[memAddr[1:0]];

  always @(posedge clk) begin
    if (preload) wordMem[preIdx] <= preWord;
    else if (memWe)
      for (int l = 0; l < 4; l++)
        if (memBe[l]) wordMem[memAddr[1:0]][8*l +: 8] <= memWdata[8*l +: 8];
  end

  // Byte-addressed reference model
  logic [7:0]  refMem [16];
  logic [31:0] lastRsp = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] laneOf(input int a, input bit be);
    return be ? 2'(3 - (a & 3)) : 2'(a & 3);
  endfunction

  function automatic bit isFault(input int a, input int sz, input bit ca);
    return ca && ((sz == 1 && (a & 1) != 0) || (sz >= 2 && (a & 3) != 0));
  endfunction

  function automatic logic [31:0] expLoad(input int a, input int sz, input bit sgn, input bit be);
    logic [31:0] v;
    logic [63:0] d;
    int h, w;
    if (sz == 0) begin
      v = {24'(0), refMem[a]};
      if (sgn && v[7]) v[31:8] = '1;
    end else if (sz == 1) begin
      h = a & 14;
      v[15:0] = be ? {refMem[h], refMem[h+1]} : {refMem[h+1], refMem[h]};
      v[31:16] = (sgn && v[15]) ? 16'hFFFF : 16'h0000;
    end else begin
      w = a & 12;
      v = be ? {refMem[w], refMem[w+1], refMem[w+2], refMem[w+3]}
             : {refMem[w+3], refMem[w+2], refMem[w+1], refMem[w]};
      d = {v, v} >> (8 * (a & 3));
      v = d[31:0];
    end
    return v;
  endfunction

  task automatic refStore(input int a, input int sz, input logic [31:0] wd, input bit be);
    int h, w;
    if (sz == 0) refMem[a] = wd[7:0];
    else if (sz == 1) begin
      h = a & 14;
      if (be) begin refMem[h] = wd[15:8]; refMem[h+1] = wd[7:0]; end
      else    begin refMem[h] = wd[7:0];  refMem[h+1] = wd[15:8]; end
    end else begin
      w = a & 12;
      for (int i = 0; i < 4; i++)
        refMem[w+i] = be ? wd[8*(3-i) +: 8] : wd[8*i +: 8];
    end
  endtask

  task automatic access(input int a, input int sz, input bit wr, input bit sgn, input logic [31:0] wd);
    bit f;
    logic [3:0]  expBe;
    logic [31:0] expWd, expRsp;
    int h;
    f = isFault(a, sz, checkAlign);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ADDR_W'(a); reqSize = 2'(sz);
    reqWrite = wr; reqSigned = sgn; reqWdata = wd;
    #1;
    chk(memAddr == 30'(a >> 2), "R1 word address", 32'(memAddr), 32'(a >> 2));
    if (wr) begin
      if (f) begin
        chk(memWe == 1'b0, "R7 write suppressed", 32'(memWe), 32'd0);
      end else begin
        if (sz == 0) begin
          expBe = 4'b1 << laneOf(a, bigEndian);
          expWd = {4{wd[7:0]}};
          chk(memBe == expBe && memWdata == expWd, "R2 byte lanes",
              {memBe, memWdata[27:0]}, {expBe, expWd[27:0]});
        end else if (sz == 1) begin
          h = a & 14;
          expBe = (4'b1 << laneOf(h, bigEndian)) | (4'b1 << laneOf(h + 1, bigEndian));
          expWd = {2{wd[15:0]}};
          chk(memBe == expBe && memWdata == expWd, "R3 half lanes",
              {memBe, memWdata[27:0]}, {expBe, expWd[27:0]});
        end else begin
          chk(memBe == 4'hF && memWdata == wd && memWe, "R4 word lanes",
              {memBe, memWdata[27:0]}, {4'hF, wd[27:0]});
        end
      end
    end
    if (!wr && !f) expRsp = expLoad(a, sz, sgn, bigEndian);
    else           expRsp = lastRsp;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    chk(rspValid == !f && abort == f, f ? "R7 abort pulse" : "R8 response valid",
        {30'd0, rspValid, abort}, {30'd0, !f, f});
    if (!wr)
      chk(rspData == expRsp, f ? "R7 data held" : (sz == 2 ? "R6 word load" : "R5 subword load"),
          rspData, expRsp);
    lastRsp = rspData;
    if (wr && !f) refStore(a, sz, wd, bigEndian);
  endtask

  task automatic fillMem(input bit be);
    for (int i = 0; i < 16; i++) refMem[i] = 8'(i * 8'h1D) ^ 8'hA5;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      preload = 1'b1; preIdx = 2'(w);
      for (int l = 0; l < 4; l++)
        preWord[8*l +: 8] = refMem[w*4 + (be ? 3 - l : l)];
    end
    @(negedge clk);
    preload = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rspValid == 0 && abort == 0 && rspData == 0, "R8 reset state",
        {rspData[29:0], rspValid, abort}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    // Idle cycle gives no response
    @(posedge clk); #1;
    chk(rspValid == 0 && abort == 0, "R8 idle quiet", {30'd0, rspValid, abort}, 32'd0);

    for (int be = 0; be < 2; be++) begin
      for (int ca = 0; ca < 2; ca++) begin
        bigEndian = be[0]; checkAlign = ca[0];
        fillMem(be[0]);
        for (int sz = 0; sz < 3; sz++) begin
          for (int off = 0; off < 4; off++) begin
            access(4 + off, sz, 1'b1, 1'b0,
                   32'h9AF37CE5 + 32'(off) * 32'h01410161 + 32'(sz) * 32'h10203040);
            for (int lsz = 0; lsz < 3; lsz++)
              for (int loff = 0; loff < 4; loff++)
                for (int sg = 0; sg < 2; sg++)
                  access(4 + loff, lsz, 1'b0, sg[0], 32'h0);
          end
        end
        // Known value round trip, R9
        access(8, 2, 1'b1, 1'b0, 32'h12345678);
        access(8, 0, 1'b0, 1'b0, 32'h0);
        chk(rspData == (be[0] ? 32'h12 : 32'h78), "R9 byte at base", rspData,
            be[0] ? 32'h12 : 32'h78);
        access(11, 0, 1'b0, 1'b0, 32'h0);
        chk(rspData == (be[0] ? 32'h78 : 32'h12), "R9 byte at base+3", rspData,
            be[0] ? 32'h78 : 32'h12);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule